// File: doc/BRIEF.md
# Lowest-Set-Bit Mask Execution Unit

This block is one execution slice of an integer pipeline. It takes a source operand and returns a mask in which every bit from bit 0 up to and including the lowest set bit of the source is one and every higher bit is zero. It computes the mask as the source XOR the source minus one. A zero source has no lowest set bit, so the mask becomes all ones at the active size and the carry flag is raised.

The processor mode and the decoded prefix bits set the operand size and decide whether the operation is legal. In 64-bit mode a width bit picks 64-bit or 32-bit operation. In every other mode the operation is always 32 bits wide and the width bit has no effect. A nonzero length bit, or an attempt in real mode or virtual-8086 mode, raises an invalid-opcode fault. A faulting operation writes neither the destination nor the flags.

All results are registered and appear one clock after the issue strobe. The destination, the flags and the fault are each valid for that one cycle only.

Top module: `lsb_mask_unit`

## Requirements
- R1: One cycle after an issue, `dst_data` equals (src − 1) XOR src computed at the active operand size, with `dst_we` high, provided the operation does not fault.
- R2: If the source is zero at the active size, the result is all ones at that size and `flg_carry` is 1. Any nonzero source gives `flg_carry` 0.
- R3: `flg_sign` equals the top bit of the result at the active size: bit 63 in 64-bit operation, bit 31 in 32-bit operation.
- R4: Whenever `flg_valid` is high, `flg_zero` and `flg_ovf` are 0.
- R5: With `cpu_mode` 3 (64-bit), `op_w` = 1 selects 64-bit operation and `op_w` = 0 selects 32-bit operation. With `cpu_mode` 2 (protected/compatibility), operation is 32-bit whatever `op_w` is.
- R6: An issue with `op_l` = 1 raises `ud_fault` one cycle later, in any mode.
- R7: An issue with `cpu_mode` 0 (real) or 1 (virtual-8086) raises `ud_fault` one cycle later.
- R8: In a cycle where `ud_fault` is high, `dst_we`, `flg_valid` and `flg_mask` are 0 and `dst_data` is 0.
- R9: In 32-bit operation, `dst_data[63:32]` is 0.
- R10: `flg_mask` is 4'b1111 when `flg_valid` is high and 4'b0000 otherwise. Bit 0 covers sign, bit 1 zero, bit 2 carry and bit 3 overflow.
- R11: After reset, and in the cycle after any clock with `issue` low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Operation presented this cycle |
| src | input | 64 | Source operand |
| cpu_mode | input | 2 | 0 real, 1 virtual-8086, 2 protected/compatibility, 3 64-bit |
| op_l | input | 1 | Decoded vector length bit; must be 0 |
| op_w | input | 1 | Decoded width bit |
| dst_data | output | 64 | Mask result, zero-extended in 32-bit operation |
| dst_we | output | 1 | Destination write enable |
| flg_sign | output | 1 | Sign flag |
| flg_zero | output | 1 | Zero flag, always cleared |
| flg_carry | output | 1 | Carry flag, set for a zero source |
| flg_ovf | output | 1 | Overflow flag, always cleared |
| flg_valid | output | 1 | Flags are written this cycle |
| flg_mask | output | 4 | Which flags are written (bit 0 sign, 1 zero, 2 carry, 3 overflow) |
| ud_fault | output | 1 | Invalid-opcode fault |

## Verification
Every output is due exactly one rising edge after the cycle in which `issue` was sampled high: the destination, all four flags, the flag mask and the fault. The bench drives each operation on a falling edge and checks the outputs on the next falling edge. At that point the single register stage has loaded the result and no new edge has replaced it. An idle cycle is checked the same way, one edge after `issue` is dropped, so a result that lingers past its one cycle is caught.

// File: rtl/lsb_mask_unit.sv
module lsb_mask_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [XLEN-1:0] src,
  input  logic [1:0]      cpu_mode,
  input  logic            op_l,
  input  logic            op_w,
  output logic [XLEN-1:0] dst_data,
  output logic            dst_we,
  output logic            flg_sign,
  output logic            flg_zero,
  output logic            flg_carry,
  output logic            flg_ovf,
  output logic            flg_valid,
  output logic [3:0]      flg_mask,
  output logic            ud_fault
);
  localparam int HALF = XLEN / 2;
  localparam logic [1:0] M_REAL = 2'd0;
  localparam logic [1:0] M_V86  = 2'd1;
  localparam logic [1:0] M_LONG = 2'd3;

  logic            wide, bad, good, src_zero, sign_c;
  logic [XLEN-1:0] src_act, mask_all, result;

  assign wide     = (cpu_mode == M_LONG) && op_w;
  assign bad      = op_l || (cpu_mode == M_REAL) || (cpu_mode == M_V86);
  assign good     = issue && !bad;
  assign src_act  = wide ? src : {{HALF{1'b0}}, src[HALF-1:0]};
  assign mask_all = (src_act - 1'b1) ^ src_act;
  assign result   = wide ? mask_all : {{HALF{1'b0}}, mask_all[HALF-1:0]};
  assign src_zero = (src_act == '0);
  assign sign_c   = wide ? result[XLEN-1] : result[HALF-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_data  <= '0;
      dst_we    <= 1'b0;
      flg_sign  <= 1'b0;
      flg_carry <= 1'b0;
      flg_valid <= 1'b0;
      ud_fault  <= 1'b0;
    end else begin
      dst_data  <= good ? result : '0;
      dst_we    <= good;
      flg_sign  <= good && sign_c;
      flg_carry <= good && src_zero;
      flg_valid <= good;
      ud_fault  <= issue && bad;
    end
  end

  assign flg_zero = 1'b0;
  assign flg_ovf  = 1'b0;
  assign flg_mask = {4{flg_valid}};

  p_mask_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> (dst_data != '0) && ((dst_data & (dst_data + 1'b1)) == '0));

  p_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flg_valid |-> flg_carry == ($past(wide) ? ($past(src) == '0)
                                            : ($past(src[HALF-1:0]) == '0)));

  p_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flg_valid |-> flg_sign == ($past(wide) ? dst_data[XLEN-1] : dst_data[HALF-1]));

  p_flags_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flg_valid |-> !flg_zero && !flg_ovf);

  p_len_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_l |=> ud_fault);

  p_mode_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (cpu_mode == M_REAL || cpu_mode == M_V86) |=> ud_fault);

  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> !dst_we && !flg_valid && dst_data == '0);

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we && !$past(wide) |-> dst_data[XLEN-1:HALF] == '0);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !dst_we && !flg_valid && !ud_fault);
endmodule

// File: tb/tb_lsb_mask_unit.sv
module tb_lsb_mask_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [63:0] src = '0;
  logic [1:0]  cpu_mode = 2'd3;
  logic        op_l = 1'b0;
  logic        op_w = 1'b0;
  logic [63:0] dst_data;
  logic        dst_we, flg_sign, flg_zero, flg_carry, flg_ovf, flg_valid, ud_fault;
  logic [3:0]  flg_mask;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lsb_mask_unit dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .src(src), .cpu_mode(cpu_mode),
    .op_l(op_l), .op_w(op_w), .dst_data(dst_data), .dst_we(dst_we),
    .flg_sign(flg_sign), .flg_zero(flg_zero), .flg_carry(flg_carry),
    .flg_ovf(flg_ovf), .flg_valid(flg_valid), .flg_mask(flg_mask),
    .ud_fault(ud_fault)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mask(input logic [63:0] s, input bit w64);
    logic [63:0] r;
    int b;
    r = '0;
    for (int i = 0; i < (w64 ? 64 : 32); i++) begin
      r[i] = 1'b1;
      b = i;
      if (s[i]) break;
    end
    return r;
  endfunction

  task automatic run_op(input logic [63:0] s, input logic [1:0] m, input bit l,
                        input bit w);
    bit          flt, w64, zs;
    logic [63:0] em;
    issue = 1'b1; src = s; cpu_mode = m; op_l = l; op_w = w;
    flt = l || (m == 2'd0) || (m == 2'd1);
    w64 = (m == 2'd3) && w;
    zs  = w64 ? (s == 64'd0) : (s[31:0] == 32'd0);
    em  = ref_mask(s, w64);
    @(negedge clk);
    if (flt) begin
      chk(ud_fault == 1'b1, l ? "R6 length fault" : "R7 mode fault", 64'(ud_fault), 64'd1);
      chk(!dst_we && !flg_valid && flg_mask == 4'd0 && dst_data == '0,
          "R8 fault quiet", dst_data, 64'd0);
    end else begin
      chk(dst_data == em && dst_we && !ud_fault, "R1 R5 R9 mask result", dst_data, em);
      chk(flg_carry == zs, "R2 carry", 64'(flg_carry), 64'(zs));
      chk(flg_sign == (w64 ? em[63] : em[31]), "R3 sign", 64'(flg_sign),
          64'(w64 ? em[63] : em[31]));
      chk(!flg_zero && !flg_ovf && flg_valid, "R4 zero/ovf cleared",
          {62'd0, flg_zero, flg_ovf}, 64'd0);
      chk(flg_mask == 4'b1111, "R10 flag mask", 64'(flg_mask), 64'hF);
    end
  endtask

  task automatic idle_chk();
    issue = 1'b0;
    @(negedge clk);
    chk(!dst_we && !flg_valid && !ud_fault && dst_data == '0 && flg_mask == 4'd0 &&
        !flg_carry && !flg_sign, "R11 idle outputs", dst_data, 64'd0);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!dst_we && !flg_valid && !ud_fault && dst_data == '0, "R11 reset state",
        dst_data, 64'd0);
    @(negedge clk);

    // directed corner cases
    run_op(64'd0, 2'd3, 0, 1);                       // R2 zero, 64-bit
    run_op(64'd0, 2'd3, 0, 0);                       // R2 zero, 32-bit
    run_op(64'hFFFF_FFFF_0000_0000, 2'd3, 0, 0);     // R2 R9 zero low half
    run_op(64'hFFFF_FFFF_0000_0000, 2'd3, 0, 1);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 1);
    run_op(64'h8000_0000_0000_0000, 2'd3, 0, 1);     // R3 sign boundary 64
    run_op(64'h0000_0000_8000_0000, 2'd2, 0, 1);     // R3 R5 sign boundary 32
    run_op(64'h0000_0000_8000_0000, 2'd3, 0, 1);
    run_op(64'h0000_0001_0000_0000, 2'd2, 0, 1);     // R5 width bit ignored
    run_op(64'd0, 2'd0, 0, 0);                       // R7 real
    run_op(64'd5, 2'd1, 0, 1);                       // R7 v86
    run_op(64'd5, 2'd3, 1, 1);                       // R6 length
    idle_chk();
    for (int b = 0; b < 64; b++) begin
      run_op(64'd1 << b, 2'd3, 0, 1);
      run_op(64'd1 << b, 2'd3, 0, 0);
    end
    idle_chk();

    for (int n = 0; n < 3000; n++) begin
      logic [63:0] s;
      logic [1:0]  m;
      bit          l, w;
      s = {$urandom, $urandom};
      case ($urandom % 4)
        0: s = s & ~((64'd1 << ($urandom % 64)) - 64'd1);
        1: s = s << ($urandom % 64);
        default: ;
      endcase
      m = ($urandom % 4 == 0) ? 2'($urandom % 2) : 2'(2 + $urandom % 2);
      l = ($urandom % 10 == 0);
      w = $urandom % 2;
      run_op(s, m, l, w);
      if ($urandom % 16 == 0) idle_chk();
    end
    idle_chk();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule